// File: doc/BRIEF.md
# Asynchronous Byte-Lane Memory Controller

This block sits between a synchronous core and an asynchronous 16-bit static memory with separate byte-lane enables. It takes one request at a time: a word address, a read/write flag, write data and a two-bit lane mask. For each request it runs a complete memory pin cycle, and when the cycle is done it pulses a one-clock ready signal. For reads, the captured word comes back with that pulse.

Every memory timing limit is met by counting system clocks. The clock period and each limit in nanoseconds are parameters. Each count is rounded up at elaboration and is never less than one clock per phase.

Writes are shaped so that the write strobe falls after chip enable and rises before it. Output enable stays high for the whole write, so the shorter address-to-end-of-write limit applies. Reads keep the data bus undriven. They are followed by a bus turnaround gap before any write data is driven. A power-good input blocks all traffic until a long hold interval has passed with power good. The hold starts again after every loss of power, and an access that is in flight when power drops is cut short.

Top module: `amc_ctrl`

## Requirements
- R1: From reset, and while power-good has been high for fewer than ceil(HOLD_NS/CLK_PERIOD_NS) clocks, `mem_ce_no` and `mem_we_no` stay high even with a request pending.
- R2: When `pwr_good_i` is low at a clock edge, `mem_ce_no` and `mem_we_no` are high after that edge and the access in flight ends with no ready pulse. The hold of R1 restarts, and a request still held is then carried out in full.
- R3: In a write, chip enable, both lane enables, `mem_addr_o` (the request address) and the driven data become active together. `mem_we_no` falls exactly one clock later and stays low for N_WP clocks. It rises while chip enable is still low.
- R4: The counts are N_WP = max(ceil(15/P), ceil(18/P)-1, ceil(10/P)-1), N_REC = max(ceil(12/P), ceil(35/P)-1-N_WP, 1), N_RD = max(ceil(35/P), ceil(15/P)) and N_TURN = ceil(10/P), where P is the clock period in ns. A write holds chip enable low for 1+N_WP+N_REC clocks.
- R5: Whenever `mem_we_no` is low, `mem_oe_no` is high and `mem_dq_oe_o` is high.
- R6: A read holds chip enable, output enable and the selected lane enables low for N_RD clocks with `mem_dq_oe_o` low. The word is captured at the edge that ends this count, with lanes outside the mask returned as zero, and it appears on `rdata_o` with the ready pulse.
- R7: After output enable rises at the end of a read, `mem_dq_oe_o` does not rise for at least N_TURN clocks.
- R8: Mask bit 1 selects the upper lane (`mem_ub_no` low) and bit 0 the lower lane (`mem_lb_no` low). A write changes only the selected lanes. The lane enables do not change while the write strobe is low.
- R9: A request with mask 00 pulses `ready_o` one clock after it is accepted, without chip enable ever falling and without changing memory.
- R10: `ready_o` is high for exactly one clock per request. `rdata_o` keeps the last read word until the next read completes.
- R11: During reset, all memory strobes are high, `mem_dq_oe_o` is low and `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply above the write-inhibit level |
| req_i | input | 1 | Request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| bmask_i | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data |
| mem_addr_o | output | 17 | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper lane enable, active low |
| mem_lb_no | output | 1 | Lower lane enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
A loss of power and an active write strobe can fall in the same cycle. The bench provokes this by dropping power-good at the sample where the write strobe is first seen low. It then expects both strobes high one clock later, no ready pulse, a new full hold before chip enable falls again, and a correct read-back of the retried write. The second collision is a read's final capture and a write that follows at once. It is judged by counting clocks with output enable high before the data drive turns on.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WREC, ST_RACC, ST_TURN
  } amc_state_e;

  function automatic int unsigned clk_cnt(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/amc_pwr_hold.sv
module amc_pwr_hold #(
  parameter int unsigned HOLD_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic pwr_ok_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == CW'(HOLD_CYC - 1)) ok_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwr_ok_o = ok_q;

  a_r1_ok_only_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !pwr_ok_o);
endmodule

// File: rtl/amc_phase_timer.sv
module amc_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 16,
  parameter int unsigned N_WP   = 2,
  parameter int unsigned N_REC  = 2,
  parameter int unsigned N_RD   = 4,
  parameter int unsigned N_TURN = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               pwr_good_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW/8-1:0]    bmask_i,
  output logic               ready_o,
  output logic [DW-1:0]      rdata_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_ce_no,
  output logic               mem_we_no,
  output logic               mem_oe_no,
  output logic [DW/8-1:0]    mem_be_no,
  output logic [DW-1:0]      mem_dq_o,
  output logic               mem_dq_oe_o,
  input  logic [DW-1:0]      mem_dq_i
);
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned MAXC = umax(umax(N_WP, N_REC), umax(N_RD, N_TURN));
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  amc_state_e     st_q, st_d;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q, lane_keep;
  logic [NB-1:0]  mask_q;
  logic           ready_q, ready_d;
  logic           ld, zero, capture, accept;
  logic [CW-1:0]  ld_val;

  amc_phase_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(zero)
  );

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    ready_d = 1'b0;
    capture = 1'b0;
    accept  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_i && req_i && !ready_q) begin
        accept = 1'b1;
        if (bmask_i == '0) ready_d = 1'b1;
        else if (we_i) begin st_d = ST_WSET; ld = 1'b1; ld_val = '0; end
        else begin st_d = ST_RACC; ld = 1'b1; ld_val = CW'(N_RD - 1); end
      end
      ST_WSET: if (zero) begin st_d = ST_WPUL; ld = 1'b1; ld_val = CW'(N_WP - 1); end
      ST_WPUL: if (zero) begin st_d = ST_WREC; ld = 1'b1; ld_val = CW'(N_REC - 1); end
      ST_WREC: if (zero) begin st_d = ST_IDLE; ready_d = 1'b1; end
      ST_RACC: if (zero) begin
        st_d = ST_TURN; ld = 1'b1; ld_val = CW'(N_TURN - 1);
        ready_d = 1'b1; capture = 1'b1;
      end
      ST_TURN: if (zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (!pwr_good_i) begin
      st_d    = ST_IDLE;
      ready_d = 1'b0;
      capture = 1'b0;
      accept  = 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_keep[8*b +: 8] = {8{mask_q[b]}};
    assign mem_be_no[b]        = mem_ce_no | ~mask_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ready_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      ready_q <= ready_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= bmask_i;
      end
      if (capture) rdata_q <= mem_dq_i & lane_keep;
    end
  end

  assign mem_ce_no   = !(st_q inside {ST_WSET, ST_WPUL, ST_WREC, ST_RACC});
  assign mem_we_no   = (st_q != ST_WPUL);
  assign mem_oe_no   = (st_q != ST_RACC);
  assign mem_dq_oe_o = (st_q inside {ST_WSET, ST_WPUL, ST_WREC});
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign ready_o     = ready_q;
  assign rdata_o     = rdata_q;

  // strobe-width observer for the checks below
  logic [CW-1:0] wlc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wlc_q <= '0;
    else if (st_q == ST_WPUL) wlc_q <= wlc_q + 1'b1;
    else                      wlc_q <= '0;
  end

  a_r3_we_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);
  a_r3_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_WREC) |-> ($past(wlc_q) == CW'(N_WP - 1)));
  a_r5_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_dq_oe_o));
  a_r6_no_drive_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  a_r8_lanes_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> $stable(mem_be_no));
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned HOLD_NS       = 2000000,
  parameter int unsigned T_CYC_NS      = 35,
  parameter int unsigned T_WP_NS       = 15,
  parameter int unsigned T_AW_NS       = 18,
  parameter int unsigned T_DW_NS       = 10,
  parameter int unsigned T_WR_NS       = 12,
  parameter int unsigned T_ACC_NS      = 35,
  parameter int unsigned T_BA_NS       = 15,
  parameter int unsigned T_OEZ_NS      = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_good_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [16:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic [1:0]  bmask_i,
  output logic        ready_o,
  output logic [15:0] rdata_o,
  output logic [16:0] mem_addr_o,
  output logic        mem_ce_no,
  output logic        mem_we_no,
  output logic        mem_oe_no,
  output logic        mem_ub_no,
  output logic        mem_lb_no,
  output logic [15:0] mem_dq_o,
  output logic        mem_dq_oe_o,
  input  logic [15:0] mem_dq_i
);
  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned HOLD_CYC = clk_cnt(HOLD_NS, P);
  localparam int unsigned N_WP     = umax(umax(clk_cnt(T_WP_NS, P), clk_cnt(T_AW_NS, P) - 1),
                                          clk_cnt(T_DW_NS, P) - 1);
  localparam int unsigned CYC_C    = clk_cnt(T_CYC_NS, P);
  localparam int unsigned N_REC    = umax(clk_cnt(T_WR_NS, P),
                                          (CYC_C > 1 + N_WP) ? CYC_C - 1 - N_WP : 1);
  localparam int unsigned N_RD     = umax(clk_cnt(T_ACC_NS, P), clk_cnt(T_BA_NS, P));
  localparam int unsigned N_TURN   = clk_cnt(T_OEZ_NS, P);

  logic       pwr_ok;
  logic [1:0] be_n;

  amc_pwr_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .pwr_ok_o  (pwr_ok)
  );

  amc_seq #(
    .AW(17), .DW(16), .N_WP(N_WP), .N_REC(N_REC), .N_RD(N_RD), .N_TURN(N_TURN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (pwr_ok & pwr_good_i),
    .pwr_good_i (pwr_good_i),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .bmask_i    (bmask_i),
    .ready_o    (ready_o),
    .rdata_o    (rdata_o),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_we_no  (mem_we_no),
    .mem_oe_no  (mem_oe_no),
    .mem_be_no  (be_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i   (mem_dq_i)
  );

  assign mem_ub_no = be_n[1];
  assign mem_lb_no = be_n[0];

  a_r1_quiet_unpowered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |=> (mem_ce_no && mem_we_no));
  a_r2_abort_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (mem_ce_no && mem_we_no && !ready_o));
endmodule

// File: tb/amc_ctrl_tb.sv
module amc_ctrl_tb_top;
  localparam int TP      = 10;
  localparam int HOLD_NS = 2000;

  function automatic int cd(input int ns);
    int c;
    c = (ns + TP - 1) / TP;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HOLD_E   = cd(HOLD_NS);
  localparam int N_WP_E   = mx(mx(cd(15), cd(18) - 1), cd(10) - 1);
  localparam int N_REC_E  = mx(cd(12), mx(cd(35) - 1 - N_WP_E, 1));
  localparam int N_RD_E   = mx(cd(35), cd(15));
  localparam int N_TURN_E = cd(10);
  localparam int N_WTOT_E = 1 + N_WP_E + N_REC_E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bmask = '0;
  logic        ready_o;
  logic [15:0] rdata_o, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr_o;
  logic        mem_ce_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_dq_oe_o;

  always #5 clk = ~clk;

  amc_ctrl #(.CLK_PERIOD_NS(TP), .HOLD_NS(HOLD_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .bmask_i(bmask),
    .ready_o(ready_o), .rdata_o(rdata_o), .mem_addr_o(mem_addr_o),
    .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no),
    .mem_ub_no(mem_ub_no), .mem_lb_no(mem_lb_no), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  // memory model, 64 words on address bits [5:0]
  logic [15:0] model [64];
  logic [15:0] shadow [64];
  logic [15:0] mword;
  assign mword    = model[mem_addr_o[5:0]];
  assign mem_dq_i = (!mem_ce_no && !mem_oe_no)
                    ? {mem_ub_no ? 8'h5A : mword[15:8], mem_lb_no ? 8'hA5 : mword[7:0]}
                    : 16'hFFFF;

  int tests = 0, fails = 0, mtests = 0, mfails = 0;
  bit mon_off = 1'b1;
  logic [16:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    mtests++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin monitor
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  int ce_run = 0, we_run = 0, oe_run = 0, oehi_run = 1000, ce_falls = 0;
  bit wr_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !mon_off) begin
      if (p_we && !mem_we_no)
        mchk(ce_run == 1 && !mem_ce_no, "R3 chip enable leads strobe by one clock", ce_run, 1);
      if (!p_we && mem_we_no) begin
        mchk(we_run == N_WP_E, "R3 strobe width", we_run, N_WP_E);
        mchk(!mem_ce_no, "R3 strobe rises before chip enable", mem_ce_no, 0);
        mchk(mem_dq_oe_o && mem_oe_no, "R5 data driven, output enable high", {mem_dq_oe_o, mem_oe_no}, 3);
        mchk(mem_addr_o == exp_addr, "R3 address", mem_addr_o, exp_addr);
      end
      if (!mem_we_no)
        mchk(mem_oe_no && mem_dq_oe_o, "R5 output enable during strobe", {mem_dq_oe_o, mem_oe_no}, 3);
      if (!p_ce && mem_ce_no && wr_seen)
        mchk(ce_run == N_WTOT_E, "R4 write chip-enable length", ce_run, N_WTOT_E);
      if (!p_oe && mem_oe_no)
        mchk(oe_run == N_RD_E, "R6 read access length", oe_run, N_RD_E);
      if (!mem_oe_no)
        mchk(!mem_dq_oe_o, "R6 bus undriven in read", mem_dq_oe_o, 0);
      if (!p_dqoe && mem_dq_oe_o)
        mchk(oehi_run >= N_TURN_E, "R7 turnaround gap", oehi_run, N_TURN_E);
    end
    if (!p_we && mem_we_no && !mem_ce_no) begin
      if (!mem_ub_no) model[mem_addr_o[5:0]][15:8] <= mem_dq_o[15:8];
      if (!mem_lb_no) model[mem_addr_o[5:0]][7:0]  <= mem_dq_o[7:0];
    end
    if (p_ce && !mem_ce_no) ce_falls++;
    if (!mem_we_no) wr_seen = 1'b1;
    else if (mem_ce_no) wr_seen = 1'b0;
    ce_run   = mem_ce_no ? 0 : ce_run + 1;
    we_run   = mem_we_no ? 0 : we_run + 1;
    oe_run   = mem_oe_no ? 0 : oe_run + 1;
    oehi_run = mem_oe_no ? oehi_run + 1 : 0;
    p_ce = mem_ce_no; p_we = mem_we_no; p_oe = mem_oe_no; p_dqoe = mem_dq_oe_o;
  end

  task automatic do_op(input bit w, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; bmask = m; exp_addr = a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready_o && lat < 2000);
    rd = rdata_o;
    req = 1'b0;
    @(negedge clk);
    chk(!ready_o, "R10 ready lasts one clock", ready_o, 0);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic wr(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] rd; int lat;
    do_op(1'b1, a, d, m, rd, lat);
    if (m != 2'b00) shadow[a[5:0]] = merge(shadow[a[5:0]], d, m);
  endtask

  task automatic rd_chk(input logic [16:0] a, input logic [1:0] m, input string tag);
    logic [15:0] rd; int lat;
    do_op(1'b0, a, 16'h0, m, rd, lat);
    chk(rd == lanes(shadow[a[5:0]], m), tag, rd, lanes(shadow[a[5:0]], m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
    $finish;
  end

  initial begin
    logic [15:0] rd, last_rd;
    int lat, n, falls0;
    for (int i = 0; i < 64; i++) begin model[i] = 16'h0; shadow[i] = 16'h0; end

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(mem_ce_no && mem_we_no && mem_oe_no && mem_ub_no && mem_lb_no,
        "R11 strobes high in reset", {mem_ce_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no}, 5'h1f);
    chk(!mem_dq_oe_o && !ready_o, "R11 no drive, no ready in reset", {mem_dq_oe_o, ready_o}, 0);
    rst_n = 1'b1;

    // R1 hold after power-up with a request pending
    @(negedge clk);
    pwr_good = 1'b1; req = 1'b1; we = 1'b1; addr = 17'h1_0003; wdata = 16'hBEEF; bmask = 2'b11;
    exp_addr = addr;
    n = 0;
    while (mem_ce_no && n < 5000) begin @(negedge clk); n++; end
    chk(n >= HOLD_E, "R1 no access during hold", n, HOLD_E);
    chk(n <= HOLD_E + 3, "R1 access starts after hold", n, HOLD_E + 3);
    while (!ready_o) @(negedge clk);
    req = 1'b0;
    shadow[3] = 16'hBEEF;
    @(negedge clk);
    mon_off = 1'b0;
    rd_chk(17'h1_0003, 2'b11, "R6 read after first write");

    // R3 R4 R8 sweep of masks and addresses
    for (int m = 1; m < 4; m++)
      for (int i = 0; i < 8; i++)
        wr(17'(i * 17'h2345 + m * 7), 16'(i * 16'h1357 ^ m * 16'h0F0F ^ 16'hA5C3), 2'(m));
    for (int i = 0; i < 8; i++)
      for (int m = 1; m < 4; m++)
        rd_chk(17'(i * 17'h2345 + 7), 2'(m), "R8 lane-merged read-back");
    for (int i = 0; i < 8; i++)
      rd_chk(17'(i * 17'h2345 + 21), 2'b11, "R8 word read-back");

    // R7 write straight after a read, R10 read data held across it
    rd_chk(17'h0_0003, 2'b01, "R6 lower lane read");
    last_rd = lanes(shadow[3], 2'b01);
    wr(17'h0_0010, 16'h1234, 2'b11);
    chk(rdata_o == last_rd, "R10 read data held", rdata_o, last_rd);
    rd_chk(17'h0_0010, 2'b10, "R7 upper lane after turnaround");

    // R9 mask 00 leaves memory and pins alone
    falls0 = ce_falls;
    do_op(1'b1, 17'h0_0010, 16'hFFFF, 2'b00, rd, lat);
    chk(lat == 1, "R9 empty-mask write latency", lat, 1);
    do_op(1'b0, 17'h0_0010, 16'h0000, 2'b00, rd, lat);
    chk(lat == 1, "R9 empty-mask read latency", lat, 1);
    chk(ce_falls == falls0, "R9 chip enable untouched", ce_falls - falls0, 0);
    rd_chk(17'h0_0010, 2'b11, "R9 memory unchanged");

    // R2 power drop while the strobe is low
    @(negedge clk);
    mon_off = 1'b1;
    req = 1'b1; we = 1'b1; addr = 17'h0_0021; wdata = 16'hC0DE; bmask = 2'b11; exp_addr = addr;
    n = 0;
    while (mem_we_no && n < 50) begin @(negedge clk); n++; end
    pwr_good = 1'b0;
    @(negedge clk);
    chk(mem_ce_no && mem_we_no, "R2 strobes released on drop", {mem_ce_no, mem_we_no}, 3);
    chk(!ready_o, "R2 no ready for aborted write", ready_o, 0);
    repeat (3) @(negedge clk);
    pwr_good = 1'b1;
    n = 0;
    while (mem_ce_no && n < 5000) begin @(negedge clk); n++; end
    chk(n >= HOLD_E, "R2 hold restarts", n, HOLD_E);
    while (!ready_o) @(negedge clk);
    req = 1'b0;
    shadow[6'h21] = 16'hC0DE;
    repeat (2) @(negedge clk);
    mon_off = 1'b0;
    rd_chk(17'h0_0021, 2'b11, "R2 retried write lands");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
    $finish;
  end
endmodule